// File: doc/BRIEF.md
# Registered Funnel Barrel Shifter with Normalization Encoder

This block shifts a 32-bit word by an amount given as a 5-bit code and shows the 32-bit result as one of its two 16-bit halves. The code is always a left-rotate amount. A right shift by d positions is coded as the two's complement of d. In wrap mode the word rotates, so any contiguous 16-bit field, including one that wraps from bit 31 to bit 0, can be placed on the output. In fill mode a direction control picks how the vacated positions are filled: low positions get zeros for a left shift, and high positions get a separate sign bit for a right shift. The direction control never changes what the code means.

A leading-digit priority encoder looks at the staged input word and gives the left-shift count that normalizes it. It handles a two's-complement mantissa or a sign-magnitude mantissa. When normalization is selected, that count drives the shift array in place of the supplied code. The count is also driven out on a code port, together with a drive-enable flag. The input stage and the output stage are each a register with its own clock enable and its own bypass. All controls are plain level pins. There is no valid/ready handshake, because the clock enables already say when each stage takes new data.

Top module: `barrel_norm_shifter`

## Requirements
- R1: With `fill_mode`=0 the result is the data word rotated left by `code_in` positions (code 0 gives no rotation, code 1 moves bit 0 to bit 1, code 31 is a right rotate by one), and `dir_right` has no effect.
- R2: With `fill_mode`=1 and `dir_right`=0 the result is the data word shifted left by the code, and the vacated low bits [c-1:0] are 0.
- R3: With `fill_mode`=1 and `dir_right`=1 and code c≠0 the result is the data word shifted right by 32−c, and the bits [31:c] equal `sign_in`. With c=0 the word passes through unchanged.
- R4: `dout` shows result bits [31:16] when `hi_sel`=1 and bits [15:0] when `hi_sel`=0. `dout` is 0 while `out_en`=0.
- R5: With `tc_mode`=1 the encoder count is the left shift that brings the first bit below bit 31 that differs from bit 31 into bit 30. That count is 30−p for such a bit at position p.
- R6: With `tc_mode`=0 the count is 30−p, where p is the highest set bit among bits [30:0]. A word with no qualifying bit (all bits equal to the sign in R5, or bits [30:0] all zero here) gives 31.
- R7: With `norm_sel`=1 the shift array uses the encoder count as its code, `code_out` carries the count and `code_oe`=1. With `norm_sel`=0, `code_oe`=0.
- R8: With both bypasses off and both enables high, a new input appears on `dout` after exactly two rising edges. With exactly one bypass on it appears after one edge. With both bypasses on it appears combinationally.
- R9: With the input stage registered and `en_in`=0, a change on `din` does not reach `dout`. With the output stage registered and `en_out`=0, the output holds.
- R10: Reset (`rst_n`=0) clears both stage registers, so with both stages registered `dout` and `code_out` read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Data word |
| sign_in | input | 1 | Fill value for right shifts in fill mode |
| code_in | input | 5 | Left-rotate amount |
| fill_mode | input | 1 | 1 = fill, 0 = wrap |
| dir_right | input | 1 | Fill convention in fill mode: 1 = right, 0 = left |
| norm_sel | input | 1 | Use the encoder count as the shift code and drive it out |
| tc_mode | input | 1 | Encoder format: 1 = two's complement, 0 = sign-magnitude |
| byp_in | input | 1 | Bypass the input stage register |
| en_in | input | 1 | Clock enable of the input stage |
| byp_out | input | 1 | Bypass the output stage register |
| en_out | input | 1 | Clock enable of the output stage |
| hi_sel | input | 1 | 1 = upper half, 0 = lower half |
| out_en | input | 1 | Output enable; 0 forces `dout` to 0 |
| dout | output | 16 | Selected half of the result |
| code_out | output | 5 | Normalization count |
| code_oe | output | 1 | Drive enable for `code_out` |

## Verification
Most of the sweep runs with both stages bypassed. Each result is then due in the same cycle, so the bench drives at the falling edge and samples 2 ns later, before any rising edge can intervene. For the latency checks the stages are registered. The bench loads an old word, then presents a new one. It confirms that the old result is still on `dout` one falling edge later, and that the new one appears after the second rising edge, or after the first when a single stage is bypassed. The reset, hold and normalization checks are timed the same way. Each sample falls at a falling edge, after the rising edges that should have taken effect and before the next one.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  parameter int unsigned BSH_DW = 32;
  localparam int unsigned BSH_SW = $clog2(BSH_DW);

  typedef enum logic [1:0] {
    SH_WRAP   = 2'd0,
    SH_FILL_L = 2'd1,
    SH_FILL_R = 2'd2
  } sh_mode_e;
endpackage

// File: rtl/bsh_stage.sv
module bsh_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bypass,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  r <= '0;
    else if (en) r <= d;
  end

  assign q = bypass ? d : r;

  // R9: a stage with its enable low keeps its content
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(r));
endmodule

// File: rtl/bsh_norm_enc.sv
module bsh_norm_enc #(
  parameter int unsigned DW = 32,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] d,
  input  logic          tc,
  output logic [SW-1:0] count
);
  logic [DW-2:0] x;

  // two's complement: look for the first bit that differs from the sign
  assign x = d[DW-2:0] ^ {(DW-1){tc & d[DW-1]}};

  always_comb begin
    count = SW'(DW-1);
    for (int i = 0; i < DW-1; i++) begin
      if (x[i]) count = SW'(DW-2-i);
    end
  end

  // R5/R6: a count below DW-1 points at a qualifying bit, and nothing above it qualifies
  always_comb begin
    if (count != SW'(DW-1)) begin
      a_r5_lead_bit: assert (x[DW-2-int'(count)] == 1'b1);
      a_r6_none_above: assert ((x >> (DW-1-int'(count))) == '0);
    end
  end
endmodule

// File: rtl/bsh_shift_array.sv
module bsh_shift_array
  import bsh_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] d,
  input  logic          sign,
  input  logic [SW-1:0] code,
  input  logic          fill,
  input  logic          right,
  output logic [DW-1:0] res
);
  logic [DW-1:0] st [SW+1];
  logic [DW-1:0] lowmask;
  sh_mode_e      mode;

  assign st[0] = d;

  for (genvar g = 0; g < SW; g++) begin : g_rot
    localparam int unsigned S = 1 << g;
    assign st[g+1] = code[g] ? {st[g][DW-1-S:0], st[g][DW-1:DW-S]} : st[g];
  end

  assign lowmask = ({{(DW-1){1'b0}}, 1'b1} << code) - {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    if (!fill)      mode = SH_WRAP;
    else if (right) mode = SH_FILL_R;
    else            mode = SH_FILL_L;
  end

  always_comb begin
    unique case (mode)
      SH_FILL_L: res = st[SW] & ~lowmask;
      SH_FILL_R: res = (code == '0) ? st[SW]
                                    : ((st[SW] & lowmask) | ({DW{sign}} & ~lowmask));
      default:   res = st[SW];
    endcase
  end

  always_comb begin
    // R1: rotation neither creates nor loses ones
    if (!fill) a_r1_popcount: assert ($countones(res) == $countones(d));
    // R2: left fill empties the lowest bit whenever it moves
    if (fill && !right && code != '0) a_r2_low_zero: assert (res[0] == 1'b0);
    // R3: right fill places the sign at the top
    if (fill && right && code != '0) a_r3_top_sign: assert (res[DW-1] == sign);
  end
endmodule

// File: rtl/barrel_norm_shifter.sv
module barrel_norm_shifter
  import bsh_pkg::*;
#(
  parameter int unsigned DW = BSH_DW,
  localparam int unsigned SW = $clog2(DW),
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          sign_in,
  input  logic [SW-1:0] code_in,
  input  logic          fill_mode,
  input  logic          dir_right,
  input  logic          norm_sel,
  input  logic          tc_mode,
  input  logic          byp_in,
  input  logic          en_in,
  input  logic          byp_out,
  input  logic          en_out,
  input  logic          hi_sel,
  input  logic          out_en,
  output logic [HW-1:0] dout,
  output logic [SW-1:0] code_out,
  output logic          code_oe
);
  localparam int unsigned W1 = DW + 1 + SW;
  localparam int unsigned W2 = DW + SW;

  logic [W1-1:0] s1_q;
  logic [DW-1:0] s1_data;
  logic          s1_sign;
  logic [SW-1:0] s1_code;
  logic [SW-1:0] enc_cnt;
  logic [SW-1:0] eff_code;
  logic [DW-1:0] sh_res;
  logic [W2-1:0] s2_q;
  logic [DW-1:0] s2_res;
  logic [SW-1:0] s2_cnt;

  bsh_stage #(.W(W1)) u_in_stage (
    .clk(clk), .rst_n(rst_n), .bypass(byp_in), .en(en_in),
    .d({din, sign_in, code_in}), .q(s1_q)
  );

  assign {s1_data, s1_sign, s1_code} = s1_q;

  bsh_norm_enc #(.DW(DW)) u_enc (
    .d(s1_data), .tc(tc_mode), .count(enc_cnt)
  );

  assign eff_code = norm_sel ? enc_cnt : s1_code;

  bsh_shift_array #(.DW(DW)) u_array (
    .d(s1_data), .sign(s1_sign), .code(eff_code),
    .fill(fill_mode), .right(dir_right), .res(sh_res)
  );

  bsh_stage #(.W(W2)) u_out_stage (
    .clk(clk), .rst_n(rst_n), .bypass(byp_out), .en(en_out),
    .d({sh_res, enc_cnt}), .q(s2_q)
  );

  assign {s2_res, s2_cnt} = s2_q;

  assign dout     = !out_en ? '0 : (hi_sel ? s2_res[DW-1:HW] : s2_res[HW-1:0]);
  assign code_out = s2_cnt;
  assign code_oe  = norm_sel;

  // R7: under normalization with both stages bypassed, the array gets the count
  a_r7_norm_code: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_sel && byp_in) |-> (eff_code == code_out || !byp_out));
endmodule

// File: tb/tb_barrel_norm_shifter.sv
module tb_barrel_norm_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic        sign_in = 1'b0;
  logic [4:0]  code_in = '0;
  logic        fill_mode = 1'b0, dir_right = 1'b0, norm_sel = 1'b0, tc_mode = 1'b0;
  logic        byp_in = 1'b0, en_in = 1'b1, byp_out = 1'b0, en_out = 1'b1;
  logic        hi_sel = 1'b0, out_en = 1'b1;
  logic [15:0] dout;
  logic [4:0]  code_out;
  logic        code_oe;

  int n_chk = 0;
  int n_bad = 0;

  barrel_norm_shifter dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sign_in(sign_in), .code_in(code_in),
    .fill_mode(fill_mode), .dir_right(dir_right), .norm_sel(norm_sel), .tc_mode(tc_mode),
    .byp_in(byp_in), .en_in(en_in), .byp_out(byp_out), .en_out(en_out),
    .hi_sel(hi_sel), .out_en(out_en), .dout(dout), .code_out(code_out), .code_oe(code_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] d, input int c,
                                        input logic f, input logic r, input logic s);
    logic [63:0] t;
    if (!f) begin
      t = {d, d} << c;
      return t[63:32];
    end
    if (!r) return d << c;
    if (c == 0) return d;
    t = {{32{s}}, d} >> (32 - c);
    return t[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] pats [6];
    logic [31:0] e;
    logic [31:0] d;
    pats[0] = 32'h8000_0001; pats[1] = 32'hDEAD_BEEF; pats[2] = 32'h1234_5678;
    pats[3] = 32'hFFFF_0000; pats[4] = 32'h0F0F_3C3C; pats[5] = 32'h7FFF_FFFE;

    // R10: reset with both stages registered
    din = 32'hA5A5_A5A5; code_in = 5'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #2;
    chk("R10 dout", {16'h0, dout}, 32'h0);
    chk("R10 code_out", {27'h0, code_out}, 32'h0);
    hi_sel = 1'b1; #1;
    chk("R10 dout hi", {16'h0, dout}, 32'h0);

    // sweep R1 R2 R3 R4 with both stages bypassed
    byp_in = 1'b1; byp_out = 1'b1;
    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 3; m++) begin
        for (int c = 0; c < 32; c++) begin
          for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            din = pats[p]; code_in = 5'(c); hi_sel = h[0];
            sign_in = p[0];
            fill_mode = (m != 0);
            dir_right = (m == 0) ? c[0] : (m == 2);
            #2;
            e = model(pats[p], c, fill_mode, dir_right, sign_in);
            if (m == 0)      chk(h ? "R1 R4 wrap hi" : "R1 R4 wrap lo", {16'h0, dout}, {16'h0, h ? e[31:16] : e[15:0]});
            else if (m == 1) chk(h ? "R2 R4 left hi" : "R2 R4 left lo", {16'h0, dout}, {16'h0, h ? e[31:16] : e[15:0]});
            else             chk(h ? "R3 R4 right hi" : "R3 R4 right lo", {16'h0, dout}, {16'h0, h ? e[31:16] : e[15:0]});
          end
        end
      end
    end

    // R4: output enable low forces zero
    @(negedge clk);
    fill_mode = 1'b0; din = 32'hFFFF_FFFF; code_in = 5'd0; out_en = 1'b0; hi_sel = 1'b1; #2;
    chk("R4 out_en hi", {16'h0, dout}, 32'h0);
    hi_sel = 1'b0; #1;
    chk("R4 out_en lo", {16'h0, dout}, 32'h0);
    out_en = 1'b1; #1;
    chk("R4 enabled", {16'h0, dout}, 32'h0000_FFFF);

    // R5 R6 R7: normalization sweep
    fill_mode = 1'b1; dir_right = 1'b0; hi_sel = 1'b1;
    @(negedge clk); norm_sel = 1'b0; #2;
    chk("R7 oe off", {31'h0, code_oe}, 32'h0);
    norm_sel = 1'b1;
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 31; p++) begin
          @(negedge clk);
          tc_mode = t[0];
          d = '0;
          d[31] = s[0];
          for (int b = 30; b > p; b--) d[b] = t[0] ? s[0] : 1'b0;
          d[p] = t[0] ? ~s[0] : 1'b1;
          for (int b = 0; b < p; b++) d[b] = ((b * 7 + p) % 3) == 0;
          din = d; #2;
          chk(t[0] ? "R5 count" : "R6 count", {27'h0, code_out}, 32'(30 - p));
          chk("R7 oe", {31'h0, code_oe}, 32'h1);
          e = d << (30 - p);
          chk("R7 shifted", {16'h0, dout}, {16'h0, e[31:16]});
        end
        @(negedge clk);
        din = t[0] ? {32{s[0]}} : {s[0], 31'h0}; #2;
        chk("R6 all sign", {27'h0, code_out}, 32'd31);
      end
    end
    norm_sel = 1'b0;

    // R8: latency, both stages registered
    fill_mode = 1'b0; code_in = 5'd0; hi_sel = 1'b0;
    byp_in = 1'b0; byp_out = 1'b0;
    @(negedge clk); din = 32'h0000_1111;
    repeat (3) @(negedge clk);
    din = 32'h0000_2222;
    @(negedge clk);
    chk("R8 two-stage not early", {16'h0, dout}, 32'h1111);
    @(negedge clk);
    chk("R8 two-stage due", {16'h0, dout}, 32'h2222);
    byp_in = 1'b1; din = 32'h0000_3333;
    @(negedge clk);
    chk("R8 output-stage only", {16'h0, dout}, 32'h3333);
    byp_in = 1'b0; byp_out = 1'b1; #1;
    din = 32'h0000_4444; #1;
    chk("R8 input-stage not early", {16'h0, dout}, 32'h3333);
    @(negedge clk);
    chk("R8 input-stage only", {16'h0, dout}, 32'h4444);

    // R9: enables low hold the stages
    byp_out = 1'b0;
    repeat (2) @(negedge clk);
    en_in = 1'b0; din = 32'h0000_5555;
    repeat (3) @(negedge clk);
    chk("R9 input hold", {16'h0, dout}, 32'h4444);
    en_in = 1'b1; en_out = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 output hold", {16'h0, dout}, 32'h4444);
    en_out = 1'b1;
    @(negedge clk);
    chk("R9 release", {16'h0, dout}, 32'h5555);

    finish_run();
  end
endmodule